// File: doc/BRIEF.md
# AHB-Lite to APB Peripheral Bridge

This block sits between an AHB-Lite fabric and up to sixteen APB peripherals. Each peripheral occupies its own 4KB window. It takes single AHB transfers, registers their address and direction, and registers the write data in the following data phase. It then runs a two-phase APB transfer toward the peripheral chosen by a 4-bit slot field of the address. The AHB data phase is held with HREADYOUT low until the peripheral finishes. A normal completion returns OKAY. A peripheral error is turned into the two-cycle AHB error response.

The slot field sits directly above the 12-bit window offset. Peripherals see only the word offset inside their window. A parameter mask marks slots as unpopulated. Such a slot never gets a select line, and it answers at once with zero data and no error. The bridge is used behind an upstream decoder that raises `hsel` for the whole 64KB bridge region. `haddr` therefore carries only the slot field and the offset.

Top module: `ahbApbBridge`

## Requirements
- R1: While reset is held, hreadyout is 1, hresp is 0, every psel bit is 0 and penable is 0.
- R2: A transfer starts only in a cycle where hreadyout is high and hsel, htrans[1] and hready are all 1. In any other cycle no psel bit rises and hreadyout stays 1.
- R3: The slot index is haddr[15:12]. Bit N of psel (N = slot index) is the only psel bit raised, and paddr equals haddr[11:2] of the accepted transfer.
- R4: psel first rises two cycles after the accepted address phase, with penable 0 (setup). In the following cycle penable is 1 (access). hreadyout is 0 from the cycle after the address phase until completion.
- R5: pwrite equals hwrite of the accepted transfer. For a write, pwdata equals the hwdata presented in the cycle right after the address phase.
- R6: The access cycle repeats while the selected slot's pready is 0. During that time psel, paddr and pwdata hold their values and hreadyout stays 0.
- R7: When the selected pready is 1 and its pslverr is 0 during access, the next cycle shows hreadyout 1 and hresp 0. For a read, hrdata then holds the prdata that slot presented in that completing cycle.
- R8: When the selected pready and pslverr are both 1 during access, the next cycle shows hresp 1 with hreadyout 0. The cycle after that shows hresp 1 with hreadyout 1.
- R9: A slot whose bit is 0 in SLOT_POPULATED never sees its psel raised. A transfer to it completes after a single access cycle with hresp 0 and read data 0.
- R10: pready and pslverr of slots other than the one being addressed have no effect on the length or the response of the transfer.
- R11: A new transfer presented in a completing cycle (hreadyout high, OKAY or second error cycle) is accepted without an idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock for both bus sides |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Bridge region selected |
| haddr | input | 16 | Slot field [15:12] and window offset [11:0] |
| htrans | input | 2 | AHB transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size, word (3'b010) expected |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, high when the prior data phase ends |
| hreadyout | output | 1 | Data phase of this bridge completes |
| hresp | output | 1 | 1 signals an error response |
| hrdata | output | 32 | Read data returned to AHB |
| paddr | output | 10 | Word offset inside the slot window |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| penable | output | 1 | APB access phase |
| psel | output | 16 | One select line per slot |
| prdata | input | 512 | Read data of all slots, slot N at bits [32N+31:32N] |
| pready | input | 16 | Ready of each slot |
| pslverr | input | 16 | Error of each slot |

## Verification
The assertions assume that a master only issues word-sized, word-aligned transfers. They also assume it never drives the BUSY transfer type, because only single transfers are supported. The stimulus always uses NONSEQ with size 3'b010 and an address whose low two bits are zero. It only ever drives hready as the bridge's own hreadyout, or forces it low for a single directed cycle. The peripheral model keeps every non-addressed slot ready and erroring. Any mux mistake would therefore shorten a transfer or turn it into an error.

// File: rtl/bridgePkg.sv
package bridgePkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_ACCESS = 3'd3,
    ST_DONE   = 3'd4,
    ST_ERR1   = 3'd5,
    ST_ERR2   = 3'd6,
    ST_BAD    = 3'd7
  } bridgeState_t;

  // strobes from the control machine to the datapath
  typedef struct packed {
    logic captAddr;
    logic captData;
    logic selActive;
    logic enableOn;
    logic captRead;
  } bridgeStrb_t;

  localparam logic [2:0] HSIZE_WORD = 3'b010;

endpackage

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import bridgePkg::*;
(
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic        transActive,
  input  logic        hready,
  input  logic        selReady,
  input  logic        selErr,
  output bridgeStrb_t strb,
  output logic        hreadyout,
  output logic        hresp
);

  bridgeState_t state, stateNxt;
  logic canTake;
  logic accept;

  assign canTake = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR2);
  assign accept  = canTake && hsel && transActive && hready;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR2: stateNxt = accept ? ST_WAIT : ST_IDLE;
      ST_WAIT:   stateNxt = ST_SETUP;
      ST_SETUP:  stateNxt = ST_ACCESS;
      ST_ACCESS: begin
        if (selReady) stateNxt = selErr ? ST_ERR1 : ST_DONE;
      end
      ST_ERR1:   stateNxt = ST_ERR2;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) state <= ST_IDLE;
    else          state <= stateNxt;
  end

  always_comb begin
    strb.captAddr  = accept;
    strb.captData  = (state == ST_WAIT);
    strb.selActive = (state == ST_SETUP) || (state == ST_ACCESS);
    strb.enableOn  = (state == ST_ACCESS);
    strb.captRead  = (state == ST_ACCESS) && selReady;
  end

  assign hreadyout = canTake;
  assign hresp     = (state == ST_ERR1) || (state == ST_ERR2);

  // R8
  err_two_cycle_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R8
  err_entry_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (strb.enableOn && selReady && selErr) |=> (hresp && !hreadyout));

  // R7
  ok_entry_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (strb.enableOn && selReady && !selErr) |=> (hreadyout && !hresp));

endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import bridgePkg::*;
#(
  parameter int SLOT_BITS = 4,
  parameter int SPAN_BITS = 12,
  parameter int DATA_W = 32,
  parameter logic [(1<<SLOT_BITS)-1:0] SLOT_POPULATED = '1
) (
  input  logic                              hclk,
  input  logic                              hresetn,
  input  bridgeStrb_t                       strb,
  input  logic [SLOT_BITS+SPAN_BITS-1:2]    addrIn,
  input  logic                              writeIn,
  input  logic [DATA_W-1:0]                 hwdata,
  output logic [DATA_W-1:0]                 hrdata,
  output logic [SPAN_BITS-1:2]              paddr,
  output logic                              pwrite,
  output logic [DATA_W-1:0]                 pwdata,
  output logic                              penable,
  output logic [(1<<SLOT_BITS)-1:0]         psel,
  input  logic [(1<<SLOT_BITS)*DATA_W-1:0]  prdata,
  input  logic [(1<<SLOT_BITS)-1:0]         pready,
  input  logic [(1<<SLOT_BITS)-1:0]         pslverr,
  output logic                              selReady,
  output logic                              selErr
);

  localparam int SLOT_N = 1 << SLOT_BITS;
  localparam int ADDR_W = SLOT_BITS + SPAN_BITS;

  logic [ADDR_W-1:2]    addrReg;
  logic                 writeReg;
  logic [DATA_W-1:0]    wdataReg;
  logic [DATA_W-1:0]    rdataReg;
  logic [SLOT_BITS-1:0] slotIdx;

  logic [DATA_W-1:0] slotRd [SLOT_N];
  logic [SLOT_N-1:0] slotRdy;
  logic [SLOT_N-1:0] slotErr;

  assign slotIdx = addrReg[ADDR_W-1:SPAN_BITS];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      addrReg  <= '0;
      writeReg <= 1'b0;
    end else if (strb.captAddr) begin
      addrReg  <= addrIn;
      writeReg <= writeIn;
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)           wdataReg <= '0;
    else if (strb.captData) wdataReg <= hwdata;
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : gSlot
    if (SLOT_POPULATED[g]) begin : gPop
      assign slotRd[g]  = prdata[g*DATA_W +: DATA_W];
      assign slotRdy[g] = pready[g];
      assign slotErr[g] = pslverr[g];
      assign psel[g]    = strb.selActive && (slotIdx == SLOT_BITS'(g));
    end else begin : gEmpty
      assign slotRd[g]  = '0;
      assign slotRdy[g] = 1'b1;
      assign slotErr[g] = 1'b0;
      assign psel[g]    = 1'b0;
    end
  end

  assign selReady = slotRdy[slotIdx];
  assign selErr   = slotErr[slotIdx];

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)           rdataReg <= '0;
    else if (strb.captRead) rdataReg <= slotRd[slotIdx];
  end

  assign hrdata  = rdataReg;
  assign paddr   = addrReg[SPAN_BITS-1:2];
  assign pwrite  = writeReg;
  assign pwdata  = wdataReg;
  assign penable = strb.enableOn;

  // R3
  psel_onehot_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(psel));

  // R4
  setup_first_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(|psel) |-> !penable);

  // R6
  wait_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (penable && !selReady) |=> (penable && $stable(paddr) && $stable(pwdata) && $stable(psel)));

endmodule

// File: rtl/ahbApbBridge.sv
module ahbApbBridge
  import bridgePkg::*;
#(
  parameter int SLOT_BITS = 4,
  parameter int SPAN_BITS = 12,
  parameter int DATA_W = 32,
  parameter logic [(1<<SLOT_BITS)-1:0] SLOT_POPULATED = '1
) (
  input  logic                              hclk,
  input  logic                              hresetn,
  input  logic                              hsel,
  input  logic [SLOT_BITS+SPAN_BITS-1:0]    haddr,
  input  logic [1:0]                        htrans,
  input  logic                              hwrite,
  input  logic [2:0]                        hsize,
  input  logic [DATA_W-1:0]                 hwdata,
  input  logic                              hready,
  output logic                              hreadyout,
  output logic                              hresp,
  output logic [DATA_W-1:0]                 hrdata,
  output logic [SPAN_BITS-1:2]              paddr,
  output logic                              pwrite,
  output logic [DATA_W-1:0]                 pwdata,
  output logic                              penable,
  output logic [(1<<SLOT_BITS)-1:0]         psel,
  input  logic [(1<<SLOT_BITS)*DATA_W-1:0]  prdata,
  input  logic [(1<<SLOT_BITS)-1:0]         pready,
  input  logic [(1<<SLOT_BITS)-1:0]         pslverr
);

  localparam int ADDR_W = SLOT_BITS + SPAN_BITS;

  bridgeStrb_t strb;
  logic selReady;
  logic selErr;

  bridgeCtrl u_ctrl (
    .hclk        (hclk),
    .hresetn     (hresetn),
    .hsel        (hsel),
    .transActive (htrans[1]),
    .hready      (hready),
    .selReady    (selReady),
    .selErr      (selErr),
    .strb        (strb),
    .hreadyout   (hreadyout),
    .hresp       (hresp)
  );

  bridgeDatapath #(
    .SLOT_BITS      (SLOT_BITS),
    .SPAN_BITS      (SPAN_BITS),
    .DATA_W         (DATA_W),
    .SLOT_POPULATED (SLOT_POPULATED)
  ) u_dp (
    .hclk     (hclk),
    .hresetn  (hresetn),
    .strb     (strb),
    .addrIn   (haddr[ADDR_W-1:2]),
    .writeIn  (hwrite),
    .hwdata   (hwdata),
    .hrdata   (hrdata),
    .paddr    (paddr),
    .pwrite   (pwrite),
    .pwdata   (pwdata),
    .penable  (penable),
    .psel     (psel),
    .prdata   (prdata),
    .pready   (pready),
    .pslverr  (pslverr),
    .selReady (selReady),
    .selErr   (selErr)
  );

  // R2 input assumption: only word-sized, aligned single transfers
  word_xfer_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (hsel && hready && htrans[1]) |-> (hsize == HSIZE_WORD && haddr[1:0] == 2'b00));

  // R2 input assumption: no BUSY transfer type
  no_busy_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    hsel |-> (htrans != 2'b01));

  // R4
  stall_while_apb_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (|psel || penable) |-> !hreadyout);

endmodule

// File: tb/ahbApbBridge_tb.sv
module ahbApbBridge_tb;

  localparam int SLOT_N = 16;
  localparam int DW = 32;
  localparam logic [15:0] POP = 16'hF7FF; // slot 11 unpopulated

  logic hclk = 1'b0;
  logic hresetn = 1'b0;
  logic hsel = 1'b0;
  logic [15:0] haddr = '0;
  logic [1:0] htrans = 2'b00;
  logic hwrite = 1'b0;
  logic [2:0] hsize = 3'b010;
  logic [DW-1:0] hwdata = '0;
  logic hreadyGate = 1'b1;
  logic hready;
  logic hreadyout, hresp;
  logic [DW-1:0] hrdata;
  logic [11:2] paddr;
  logic pwrite, penable;
  logic [DW-1:0] pwdata;
  logic [SLOT_N-1:0] psel;
  logic [SLOT_N*DW-1:0] prdata;
  logic [SLOT_N-1:0] slotRdy = '1;
  logic [SLOT_N-1:0] slotErr = '1;
  logic [DW-1:0] slotData [SLOT_N];

  int tests = 0;
  int fails = 0;

  always #4 hclk = ~hclk;

  assign hready = hreadyout & hreadyGate;

  for (genvar g = 0; g < SLOT_N; g++) begin : gData
    assign prdata[g*DW +: DW] = slotData[g];
  end

  ahbApbBridge #(.SLOT_POPULATED(POP)) u_dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
    .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .penable(penable),
    .psel(psel), .prdata(prdata), .pready(slotRdy), .pslverr(slotErr)
  );

  function automatic logic [31:0] rdPattern(input int slot, input int offs);
    return (32'h1000_0000 * slot) ^ (32'h0001_0003 * offs) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge hclk);
    @(negedge hclk);
  endtask

  // starts at a negedge where hreadyout is high; ends at a negedge of a completing cycle
  task automatic xfer(input int slot, input int offs, input bit wr,
                      input logic [31:0] wdata, input int waits, input bit err);
    bit pop = POP[slot];
    int effWaits = pop ? waits : 0;
    bit effErr = pop ? err : 1'b0;
    logic [31:0] expRd = pop ? rdPattern(slot, offs) : 32'h0;
    logic [15:0] expSel = pop ? (16'h1 << slot) : 16'h0;
    for (int i = 0; i < SLOT_N; i++) slotData[i] = $urandom;
    slotRdy[slot] = 1'b0;
    slotErr[slot] = 1'b0;
    hsel = 1'b1; htrans = 2'b10; hwrite = wr; hsize = 3'b010;
    haddr = {slot[3:0], offs[9:0], 2'b00};
    cyc();
    hsel = 1'b0; htrans = 2'b00; hwdata = wdata;
    chk(hreadyout == 1'b0 && psel == 16'h0, "R4 data-phase stall", {15'h0, hreadyout, psel}, 32'h0);
    cyc();
    hwdata = $urandom;
    chk(psel == expSel, "R3/R9 psel", {16'h0, psel}, {16'h0, expSel});
    chk(penable == 1'b0, "R4 setup penable", {31'h0, penable}, 32'h0);
    chk(paddr == offs[9:0], "R3 paddr", {22'h0, paddr}, offs);
    chk(pwrite == wr, "R5 pwrite", {31'h0, pwrite}, {31'h0, wr});
    if (wr) chk(pwdata == wdata, "R5 pwdata", pwdata, wdata);
    cyc();
    for (int w = 0; w < effWaits; w++) begin
      chk(penable && !hreadyout && psel == expSel && paddr == offs[9:0],
          "R6/R10 wait hold", {penable, hreadyout, 14'h0, psel}, {2'b10, 14'h0, expSel});
      slotData[slot] = $urandom;
      cyc();
    end
    chk(penable == 1'b1 && hreadyout == 1'b0, "R4 access", {penable, hreadyout}, 2'b10);
    slotRdy[slot] = 1'b1;
    slotErr[slot] = err;
    slotData[slot] = rdPattern(slot, offs);
    cyc();
    slotRdy[slot] = 1'b1;
    slotErr[slot] = 1'b1;
    if (effErr) begin
      chk(hresp && !hreadyout, "R8 error cycle 1", {hresp, hreadyout}, 2'b10);
      cyc();
      chk(hresp && hreadyout, "R8 error cycle 2", {hresp, hreadyout}, 2'b11);
    end else begin
      chk(hreadyout && !hresp && psel == 16'h0, "R7 okay completion",
          {hresp, hreadyout, psel}, {2'b01, 16'h0});
      if (!wr) chk(hrdata == expRd, pop ? "R7 read data" : "R9 empty slot data", hrdata, expRd);
    end
  endtask

  task automatic idleCheck(input string req);
    cyc();
    chk(hreadyout == 1'b1 && psel == 16'h0 && penable == 1'b0, req,
        {penable, hreadyout, psel}, {2'b01, 16'h0});
  endtask

  initial begin
    for (int i = 0; i < SLOT_N; i++) slotData[i] = 32'hDEAD_0000 + i;
    void'($urandom(32'h0BAD_C0DE));
    repeat (3) @(posedge hclk);
    @(negedge hclk);
    chk(hreadyout && !hresp && psel == 16'h0 && !penable, "R1 reset state",
        {hreadyout, hresp, penable, psel}, {3'b100, 16'h0});
    hresetn = 1'b1;
    cyc();

    // R2: rejected address phases
    hsel = 1'b1; htrans = 2'b00; haddr = 16'h3000;
    idleCheck("R2 idle htrans");
    hsel = 1'b0; htrans = 2'b10;
    idleCheck("R2 no hsel");
    hsel = 1'b1; htrans = 2'b10; hreadyGate = 1'b0;
    idleCheck("R2 hready low");
    hsel = 1'b0; htrans = 2'b00; hreadyGate = 1'b1;
    idleCheck("R2 quiet after rejects");

    // directed cases
    xfer(3, 0, 1'b1, 32'h0000_002D, 0, 1'b0);
    idleCheck("R2 idle gap");
    xfer(3, 1, 1'b0, 32'h0, 0, 1'b0);
    xfer(0, 10'h3FF, 1'b0, 32'h0, 3, 1'b0);     // R11 back to back, R6 waits
    xfer(15, 10'h200, 1'b1, 32'hCAFE_F00D, 2, 1'b0);
    xfer(7, 5, 1'b0, 32'h0, 1, 1'b1);           // R8 error
    xfer(7, 6, 1'b1, 32'h1234_5678, 0, 1'b0);   // R11 after error
    xfer(11, 9, 1'b0, 32'h0, 3, 1'b1);          // R9 unpopulated read
    xfer(11, 9, 1'b1, 32'hFFFF_FFFF, 0, 1'b0);  // R9 unpopulated write
    idleCheck("R9 nothing left pending");

    // constrained random
    for (int n = 0; n < 80; n++) begin
      xfer($urandom % 16, $urandom % 1024, $urandom % 2, $urandom, $urandom % 4,
           ($urandom % 5) == 0);
      if ($urandom % 2) idleCheck("R2 random idle");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge hclk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule